// File: doc/BRIEF.md
# DMA Request/Acknowledge Handshake with Transfer Counter

This block is the device end of a byte-wide DMA handshake. It raises a request toward a host DMA controller while a programmed number of transfers remains and the internal byte FIFO can take part: in the write direction the FIFO must have room, in the read direction it must hold a byte. Each acknowledge from the host counts the transfer counter down by one. During that acknowledge an active write strobe pushes a byte into the FIFO and an active read strobe pops one. The acknowledge and strobe pins are asynchronous. They pass through a two-flop synchronizer, and an acknowledge counts once, on its leading (falling) edge.

An acknowledge that comes with neither strobe still counts down but moves no data. A sticky flag records this case, and a counter load clears it. The shared-request mode suits boards where several devices drive one wired request line. In that mode the block never drives the line high: it pulls low to request and otherwise floats. It also ignores the acknowledge input entirely. In normal mode the line is always driven, high to request and low when idle. The counter is loaded from a port, and a load of zero stands for the full range of 2^CNT_W transfers. A terminal-count flag goes high when the count reaches zero.

Top module: `dreq_handshake`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `fifo_push`=0, `fifo_pop`=0, `term_count`=1, `orphan_ack`=0, `req_oe`=0 and `req_level`=0, and the remaining count is zero.
- R2: A high-to-low change of `ack_n` that is sampled at rising edge k counts as one acknowledge event, and that event's effects show after edge k+2. Holding `ack_n` low for any number of cycles gives one event only.
- R3: An acknowledge event with `wr_n` low (sampled through the same two-flop delay as `ack_n`) gives a one-cycle `fifo_push` pulse.
- R4: An acknowledge event with `rd_n` low (same delay) gives a one-cycle `fifo_pop` pulse.
- R5: Each acknowledge event decrements the remaining count by one. At zero the count stays at zero and does not wrap.
- R6: A rising edge with `cnt_load`=1 sets the remaining count to `cnt_value`, or to 2^CNT_W when `cnt_value` is 0. A load takes priority over an acknowledge event at the same edge, and that event then does not decrement the count.
- R7: `term_count` is 1 exactly when the remaining count after the latest edge is zero.
- R8: An acknowledge event with both `rd_n` and `wr_n` high decrements the count, makes no push or pop, and sets `orphan_ack`. The flag stays high until a load clears it.
- R9: While `shared_mode`=1, acknowledge activity causes no count change, no push, no pop and no change to `orphan_ack`.
- R10: The request is registered. It is asserted after an edge when, at that edge, the remaining count was nonzero and either `dir_write`=1 with `fifo_full`=0, or `dir_write`=0 with `fifo_empty`=0.
- R11: With `shared_mode`=0 at the edge, the outputs are `req_oe`=1 and `req_level`=request. With `shared_mode`=1, they are `req_oe`=request and `req_level`=0, so the line is either pulled low or left floating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shared_mode | input | 1 | 1: wired request line, acknowledge ignored |
| dir_write | input | 1 | 1: host writes into FIFO; 0: host reads from FIFO |
| ack_n | input | 1 | Asynchronous active-low DMA acknowledge |
| rd_n | input | 1 | Asynchronous active-low read strobe |
| wr_n | input | 1 | Asynchronous active-low write strobe |
| cnt_load | input | 1 | Load the transfer counter |
| cnt_value | input | CNT_W | Load value; 0 means 2^CNT_W |
| fifo_full | input | 1 | FIFO has no room |
| fifo_empty | input | 1 | FIFO holds no byte |
| req_oe | output | 1 | Request line driver enable |
| req_level | output | 1 | Request line level when driven |
| fifo_push | output | 1 | One-cycle FIFO push strobe |
| fifo_pop | output | 1 | One-cycle FIFO pop strobe |
| term_count | output | 1 | Remaining count is zero |
| orphan_ack | output | 1 | Sticky: an acknowledge came without a strobe |

## Verification
A wrong remaining count shows at the ports in two places: `term_count` changes on a different edge than expected, and the request stays up or drops one cycle after that edge. A counter that wraps, or that decrements in shared mode, therefore shows within two cycles of the event that caused it. A broken edge detector or synchronizer depth moves the push, pop and orphan outputs by whole cycles, or repeats them, and the per-cycle comparison catches this on the first acknowledge. Acknowledges without strobes, loads that land on the same edge as an event, zero loads and random FIFO flags are covered so that each of these paths reaches an output.

// File: rtl/dmah_pkg.sv
package dmah_pkg;
  typedef struct packed {
    logic ack_n;
    logic rd_n;
    logic wr_n;
  } strobe_t;
  localparam int STROBE_W = $bits(strobe_t);
endpackage

// File: rtl/dmah_sync.sv
module dmah_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dmah_xfer_counter.sv
module dmah_xfer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             rem_nz,
  output logic             tc
);
  localparam int RW = CNT_W + 1;
  localparam logic [RW-1:0] FULL_RANGE = RW'(1) << CNT_W;

  logic [RW-1:0] rem, rem_nx;

  always_comb begin
    rem_nx = rem;
    if (load)
      rem_nx = (load_val == '0) ? FULL_RANGE : {1'b0, load_val};
    else if (dec && rem != '0)
      rem_nx = rem - RW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      tc  <= 1'b1;
    end else begin
      rem <= rem_nx;
      tc  <= (rem_nx == '0);
    end
  end

  assign rem_nz = (rem != '0);

  // R6: any load leaves a nonzero count
  assert_load_clears_tc_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> !tc);
  // R5: at zero without a load the count stays at zero
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    tc && !load |=> tc);
endmodule

// File: rtl/dmah_req_drive.sv
module dmah_req_drive (
  input  logic clk,
  input  logic rst,
  input  logic shared_mode,
  input  logic want,
  output logic req_oe,
  output logic req_level
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_oe    <= 1'b0;
      req_level <= 1'b0;
    end else if (shared_mode) begin
      req_oe    <= want;
      req_level <= 1'b0;
    end else begin
      req_oe    <= 1'b1;
      req_level <= want;
    end
  end

  assert_shared_never_high_R11: assert property (@(posedge clk) disable iff (rst)
    shared_mode |=> !req_level);
  assert_normal_always_drives_R11: assert property (@(posedge clk) disable iff (rst)
    !shared_mode |=> req_oe);
endmodule

// File: rtl/dreq_handshake.sv
module dreq_handshake #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shared_mode,
  input  logic             dir_write,
  input  logic             ack_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_value,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  output logic             req_oe,
  output logic             req_level,
  output logic             fifo_push,
  output logic             fifo_pop,
  output logic             term_count,
  output logic             orphan_ack
);
  import dmah_pkg::*;

  strobe_t raw_s, sync_s;
  logic [STROBE_W-1:0] sync_bits;

  assign raw_s = '{ack_n: ack_n, rd_n: rd_n, wr_n: wr_n};

  dmah_sync #(
    .W(STROBE_W), .STAGES(SYNC_STAGES), .RST_VAL({STROBE_W{1'b1}})
  ) u_sync (
    .clk(clk), .rst(rst), .d(raw_s), .q(sync_bits)
  );

  assign sync_s = strobe_t'(sync_bits);

  logic ack_a, rd_a, wr_a, ack_prev, ack_evt;
  assign ack_a = ~sync_s.ack_n;
  assign rd_a  = ~sync_s.rd_n;
  assign wr_a  = ~sync_s.wr_n;
  assign ack_evt = ack_a & ~ack_prev & ~shared_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_prev   <= 1'b0;
      fifo_push  <= 1'b0;
      fifo_pop   <= 1'b0;
      orphan_ack <= 1'b0;
    end else begin
      ack_prev  <= ack_a;
      fifo_push <= ack_evt & wr_a;
      fifo_pop  <= ack_evt & rd_a;
      if (cnt_load)
        orphan_ack <= 1'b0;
      else if (ack_evt && !rd_a && !wr_a)
        orphan_ack <= 1'b1;
    end
  end

  logic rem_nz, want;

  dmah_xfer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_value),
    .dec(ack_evt), .rem_nz(rem_nz), .tc(term_count)
  );

  assign want = rem_nz & (dir_write ? ~fifo_full : ~fifo_empty);

  dmah_req_drive u_drv (
    .clk(clk), .rst(rst), .shared_mode(shared_mode), .want(want),
    .req_oe(req_oe), .req_level(req_level)
  );

  assert_shared_ignores_ack_R9: assert property (@(posedge clk) disable iff (rst)
    shared_mode |=> !fifo_push && !fifo_pop);
  assert_tc_blocks_req_R10: assert property (@(posedge clk) disable iff (rst)
    term_count && !shared_mode |=> !req_level);
  assert_orphan_not_on_load_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(orphan_ack) |-> !$past(cnt_load));
  assert_single_push_R2: assert property (@(posedge clk) disable iff (rst)
    fifo_push |=> !fifo_push);
endmodule

// File: tb/dreq_handshake_tb.sv
module dreq_handshake_tb;
  localparam int CNT_W = 16;

  logic clk = 0, rst = 1;
  logic shared_mode = 0, dir_write = 1;
  logic ack_n = 1, rd_n = 1, wr_n = 1;
  logic cnt_load = 0;
  logic [CNT_W-1:0] cnt_value = '0;
  logic fifo_full = 0, fifo_empty = 1;
  logic req_oe, req_level, fifo_push, fifo_pop, term_count, orphan_ack;

  always #5 clk = ~clk;

  dreq_handshake #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .shared_mode(shared_mode), .dir_write(dir_write),
    .ack_n(ack_n), .rd_n(rd_n), .wr_n(wr_n), .cnt_load(cnt_load),
    .cnt_value(cnt_value), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .req_oe(req_oe), .req_level(req_level), .fifo_push(fifo_push),
    .fifo_pop(fifo_pop), .term_count(term_count), .orphan_ack(orphan_ack)
  );

  // Behavioural reference: delayed samples and an integer count
  integer rem = 0;
  bit a1, a2, ap, r1, r2, w1, w2, ev, want, started;
  bit e_push, e_pop, e_tc = 1, e_orph, e_oe, e_lvl;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      a1 = 0; a2 = 0; ap = 0; r1 = 0; r2 = 0; w1 = 0; w2 = 0;
      rem = 0; e_push = 0; e_pop = 0; e_tc = 1; e_orph = 0; e_oe = 0; e_lvl = 0;
    end else begin
      ev   = a2 && !ap && !shared_mode;
      want = (rem != 0) && (dir_write ? !fifo_full : !fifo_empty);
      e_oe  = shared_mode ? want : 1'b1;
      e_lvl = shared_mode ? 1'b0 : want;
      e_push = ev && w2;
      e_pop  = ev && r2;
      if (cnt_load) begin
        rem = (cnt_value == 0) ? (1 << CNT_W) : int'(cnt_value);
        e_orph = 0;
      end else if (ev) begin
        if (rem > 0) rem = rem - 1;
        if (!r2 && !w2) e_orph = 1;
      end
      e_tc = (rem == 0);
      ap = a2; a2 = a1; a1 = !ack_n;
      r2 = r1; r1 = !rd_n;
      w2 = w1; w1 = !wr_n;
    end
  end

  integer checks = 0, fails = 0;
  string phase = "R1";
  bit done = 0;

  task automatic chk(string rq, string nm, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL [%s/%s] %s actual=%b expected=%b at %0t", phase, rq, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R3",  "fifo_push",  fifo_push,  e_push);
      chk("R4",  "fifo_pop",   fifo_pop,   e_pop);
      chk("R7",  "term_count", term_count, e_tc);
      chk("R8",  "orphan_ack", orphan_ack, e_orph);
      chk("R11", "req_oe",     req_oe,     e_oe);
      chk("R11", "req_level",  req_level,  e_lvl);
    end
  end

  task automatic do_load(input int v);
    @(negedge clk); cnt_load = 1; cnt_value = CNT_W'(v);
    @(negedge clk); cnt_load = 0;
  endtask

  task automatic ack_cycle(input bit rd, input bit wr, input int low, input int high);
    @(negedge clk); rd_n = !rd; wr_n = !wr; ack_n = 0;
    repeat (low) @(negedge clk);
    ack_n = 1; rd_n = 1; wr_n = 1;
    repeat (high) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL [watchdog] run did not finish");
      summary();
      $finish;
    end
  end

  logic [7:0] lfsr = 8'hA5;

  initial begin
    phase = "R1";
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);

    phase = "R3";   // write direction, pushes
    dir_write = 1; fifo_full = 0;
    do_load(5);
    repeat (3) ack_cycle(0, 1, 2, 4);

    phase = "R2";   // long acknowledge counts once
    ack_cycle(0, 1, 12, 5);
    ack_cycle(0, 1, 1, 5);

    phase = "R4";   // read direction, pops
    dir_write = 0; fifo_empty = 0;
    do_load(4);
    repeat (3) ack_cycle(1, 0, 3, 3);

    phase = "R5";   // saturation at zero
    do_load(2);
    repeat (4) ack_cycle(1, 0, 2, 4);
    repeat (3) @(negedge clk);

    phase = "R7";
    do_load(1);
    ack_cycle(1, 0, 2, 6);

    phase = "R6";   // zero load means full range; load beats event
    do_load(0);
    ack_cycle(1, 0, 2, 4);
    do_load(1);
    ack_cycle(0, 0, 2, 4);
    @(negedge clk); ack_n = 0; wr_n = 0;
    cnt_load = 1; cnt_value = 3;
    repeat (4) @(negedge clk);
    cnt_load = 0; ack_n = 1; wr_n = 1;
    repeat (4) @(negedge clk);

    phase = "R8";   // acknowledge without strobe
    do_load(6);
    ack_cycle(0, 0, 2, 4);
    ack_cycle(0, 1, 2, 4);
    do_load(3);
    ack_cycle(0, 0, 2, 4);

    phase = "R9";   // shared mode ignores acknowledge
    shared_mode = 1;
    do_load(2);
    repeat (3) ack_cycle(0, 1, 2, 4);
    ack_cycle(0, 0, 2, 4);
    fifo_empty = 1;
    repeat (3) @(negedge clk);
    fifo_empty = 0;
    shared_mode = 0;
    repeat (3) @(negedge clk);

    phase = "R10";  // request versus direction and FIFO flags
    do_load(40);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      fifo_full   = lfsr[0];
      fifo_empty  = lfsr[1];
      dir_write   = lfsr[2];
      shared_mode = (lfsr[7:5] == 3'b111);
      ack_n       = lfsr[3] | lfsr[6];
      rd_n        = lfsr[4];
      wr_n        = !lfsr[4];
    end
    ack_n = 1; rd_n = 1; wr_n = 1; shared_mode = 0;
    repeat (6) @(negedge clk);

    phase = "R11";
    shared_mode = 1; dir_write = 1; fifo_full = 0;
    do_load(3);
    repeat (3) @(negedge clk);
    shared_mode = 0;
    repeat (3) @(negedge clk);

    phase = "R1";   // reset mid-run
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule